// File: doc/BRIEF.md
# Host and DMA Register-Port Decoder

This block sits between a host processor, a DMA engine and the internals of a peripheral controller. It takes five active-low host strobes (chip select, DMA acknowledge, read, write, DMA write) and a two-bit bus-mode strap. From them it produces single-cycle register-read, register-write, FIFO-pop and FIFO-push pulses toward the register file and FIFO. Each pulse comes with the decoded register address, write byte or DMA word. Every strobe is brought into the clock domain through a two-flop synchronizer, and each access acts once, on the assertion edge of its synchronized strobe.

The strap chooses among four bus arrangements. These set where the register address comes from (a dedicated address port, or the low nibble of the host data bus latched when chip select asserts), which bus carries register write data, and whether DMA words are 16 or 8 bits wide. The block reports chip-select/acknowledge overlaps that the selected arrangement forbids, and it suppresses the FIFO access while such an overlap lasts.

The block also holds the controller's non-maskable interrupt flag and drives it out as an active-low line. The flag is set by the core. It is cleared by reading the interrupt status register, by a soft reset, or by a hard reset held for the minimum time. A SCSI bus reset leaves it alone.

Top module: `hbus_port_decoder`

## Requirements
- R1: Every strobe is active low and passes a two-flop synchronizer. Each read, write or DMA write produces exactly one single-cycle pulse per assertion, however long the strobe is held.
- R2: Write low while chip select is low gives one `reg_wr_o` pulse. In modes 2'b11, 2'b01 and 2'b00 the address comes from `addr_i`. In modes 2'b11 and 2'b10 the write byte comes from `ad_i`. In modes 2'b01 and 2'b00 it comes from `dma_i[7:0]`.
- R3: In mode 2'b10 the register address is `ad_i[3:0]`, captured when synchronized chip select asserts. `addr_i` is ignored in this mode.
- R4: Read low with chip select low gives `reg_rd_o` for any address except the FIFO address 4'h2. For 4'h2 it gives `fifo_pop_o` and no `reg_rd_o`.
- R5: Read low with only DMA acknowledge low gives `fifo_pop_o` and never `reg_rd_o`. Write low with only acknowledge low gives no pulse at all.
- R6: In modes 2'b11, 2'b10 and 2'b01, DMA write low while acknowledge is low pushes `dma_i` and `dmap_i` with `fifo_cnt_o` = 2. DMA write without acknowledge pushes nothing.
- R7: In mode 2'b00 a push carries `{8'h00, dma_i[7:0]}`, parity `{1'b0, dmap_i[0]}` and `fifo_cnt_o` = 1.
- R8: Chip select and acknowledge both low is illegal in modes 2'b01/2'b00, and in modes 2'b11/2'b10 when the chip-select address is 4'h2. While illegal, `proto_err_o` is high and no push or pop occurs. A legal overlap raises no error and the push goes through.
- R9: A cycle with `irq_set_i` high drives `irq_no` low from the following clock edge, and it stays low until a clear condition.
- R10: A register read of address 4'h5 clears the flag on the clock after the `reg_rd_o` pulse, so `irq_no` is still low during that pulse.
- R11: A `soft_rst_i` pulse clears the flag. `scsi_rst_i` has no effect on it.
- R12: `hw_rst_i` clears the flag only when held high for at least 2 consecutive clock edges. A single-cycle pulse has no effect.
- R13: While `rst_ni` is low all pulse outputs and `proto_err_o` are 0 and `irq_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| mode_i | input | 2 | Bus-mode strap |
| cs_ni | input | 1 | Chip select, active low |
| dack_ni | input | 1 | DMA acknowledge, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Register write strobe, active low |
| dmawr_ni | input | 1 | DMA write strobe, active low |
| addr_i | input | 4 | Dedicated register address |
| ad_i | input | 8 | Host data bus (address nibble in mode 2'b10) |
| dma_i | input | 16 | DMA data bus |
| dmap_i | input | 2 | DMA byte parity |
| irq_set_i | input | 1 | Interrupt event from the core |
| soft_rst_i | input | 1 | Soft device reset pulse |
| hw_rst_i | input | 1 | Hard device reset, active high |
| scsi_rst_i | input | 1 | SCSI bus reset indication |
| reg_rd_o | output | 1 | Register read pulse |
| reg_wr_o | output | 1 | Register write pulse |
| reg_addr_o | output | 4 | Address of the read or write |
| reg_wdata_o | output | 8 | Register write byte |
| fifo_pop_o | output | 1 | FIFO read pulse |
| fifo_push_o | output | 1 | FIFO write pulse |
| fifo_data_o | output | 16 | Pushed DMA word |
| fifo_par_o | output | 2 | Pushed parity |
| fifo_cnt_o | output | 2 | Valid bytes in the push |
| proto_err_o | output | 1 | Illegal chip-select/acknowledge overlap |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench holds strobes low for many cycles. A decoder that acts on level instead of edge would then emit repeated pulses. The bench also drives mode 2'b10 with a misleading `addr_i`, so a design that ignores the latched nibble writes the wrong register. It also checks the narrow DMA mode, where a design that forwards the high byte or reports two bytes corrupts the FIFO. Overlap cases are exercised in both bus families and with both FIFO and non-FIFO addresses: a wrong legality rule either pushes during a forbidden overlap or flags a legal one. The interrupt tests cover the clear timing around the status read, the SCSI reset that must not clear, and a one-cycle versus two-cycle hard reset. These expose a flag that clears early, clears on the wrong event, or clears on a glitch.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [1:0] {
    MODE_SB8    = 2'b00,
    MODE_SB16   = 2'b01,
    MODE_DB_MUX = 2'b10,
    MODE_DB_SEP = 2'b11
  } bus_mode_e;

  // strobe bit positions inside the synchronizer vector
  localparam int unsigned S_CS    = 0;
  localparam int unsigned S_DACK  = 1;
  localparam int unsigned S_RD    = 2;
  localparam int unsigned S_WR    = 3;
  localparam int unsigned S_DMAWR = 4;
  localparam int unsigned N_STB   = 5;
endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_ni,
  output logic [W-1:0] act_o,
  output logic [W-1:0] rise_o
);
  // one extra stage for edge detection
  logic [STAGES:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '1;
    else         stg_q <= {stg_q[STAGES-1:0], async_ni};
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign act_o[b]  = ~stg_q[STAGES-1][b];
    assign rise_o[b] = ~stg_q[STAGES-1][b] & stg_q[STAGES][b];
  end
endmodule

// File: rtl/hbd_dec.sv
module hbd_dec
  import hbd_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 4,
  parameter int unsigned         HDATA_W   = 8,
  parameter int unsigned         DDATA_W   = 16,
  parameter int unsigned         PAR_W     = 2,
  parameter logic [ADDR_W-1:0]   FIFO_ADDR = 4'h2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [N_STB-1:0]   act_i,
  input  logic [N_STB-1:0]   rise_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [HDATA_W-1:0] ad_i,
  input  logic [DDATA_W-1:0] dma_i,
  input  logic [PAR_W-1:0]   dmap_i,
  output logic               reg_rd_o,
  output logic               reg_wr_o,
  output logic [ADDR_W-1:0]  reg_addr_o,
  output logic [HDATA_W-1:0] reg_wdata_o,
  output logic               fifo_pop_o,
  output logic               fifo_push_o,
  output logic [DDATA_W-1:0] fifo_data_o,
  output logic [PAR_W-1:0]   fifo_par_o,
  output logic [1:0]         fifo_cnt_o,
  output logic               proto_err_o
);
  localparam int unsigned HALF_D = DDATA_W / 2;
  localparam int unsigned HALF_P = PAR_W / 2;

  bus_mode_e mode;
  assign mode = bus_mode_e'(mode_i);

  logic [ADDR_W-1:0] mux_addr_q, cur_addr;
  logic single, at_fifo, illegal;
  logic rd_reg_d, pop_d, wr_d, push_d;
  logic [HDATA_W-1:0] wdata;
  logic [DDATA_W-1:0] push_data;
  logic [PAR_W-1:0]   push_par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mux_addr_q <= '0;
    else if (rise_i[S_CS] && mode == MODE_DB_MUX) mux_addr_q <= ad_i[ADDR_W-1:0];
  end

  always_comb begin
    cur_addr = (mode == MODE_DB_MUX) ? mux_addr_q : addr_i;
    single   = (mode == MODE_SB8) || (mode == MODE_SB16);
    at_fifo  = (cur_addr == FIFO_ADDR);
    illegal  = act_i[S_CS] & act_i[S_DACK] & (single | at_fifo);
    rd_reg_d = rise_i[S_RD] & act_i[S_CS] & ~at_fifo;
    pop_d    = rise_i[S_RD] & ((act_i[S_CS] & at_fifo) | act_i[S_DACK]) & ~illegal;
    wr_d     = rise_i[S_WR] & act_i[S_CS];
    push_d   = rise_i[S_DMAWR] & act_i[S_DACK] & ~illegal;
    wdata    = single ? dma_i[HDATA_W-1:0] : ad_i;
    if (mode == MODE_SB8) begin
      push_data = {{(DDATA_W-HALF_D){1'b0}}, dma_i[HALF_D-1:0]};
      push_par  = {{(PAR_W-HALF_P){1'b0}}, dmap_i[HALF_P-1:0]};
    end else begin
      push_data = dma_i;
      push_par  = dmap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rd_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      fifo_pop_o  <= 1'b0;
      fifo_push_o <= 1'b0;
      fifo_data_o <= '0;
      fifo_par_o  <= '0;
      fifo_cnt_o  <= '0;
      proto_err_o <= 1'b0;
    end else begin
      reg_rd_o    <= rd_reg_d;
      reg_wr_o    <= wr_d;
      fifo_pop_o  <= pop_d;
      fifo_push_o <= push_d;
      proto_err_o <= illegal;
      if (rd_reg_d || wr_d) reg_addr_o <= cur_addr;
      if (wr_d) reg_wdata_o <= wdata;
      if (push_d) begin
        fifo_data_o <= push_data;
        fifo_par_o  <= push_par;
        fifo_cnt_o  <= (mode == MODE_SB8) ? 2'd1 : 2'd2;
      end
    end
  end

  assert_one_shot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || reg_rd_o || fifo_push_o) |=> !(reg_wr_o || reg_rd_o || fifo_push_o));

  assert_err_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> !(fifo_push_o || fifo_pop_o));

  assert_narrow_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_push_o && $past(mode_i) == 2'b00) |->
      (fifo_cnt_o == 2'd1 && fifo_data_o[DDATA_W-1:HALF_D] == '0));

  assert_rd_not_fifo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> reg_addr_o != FIFO_ADDR);
endmodule

// File: rtl/hbd_irq.sv
module hbd_irq #(
  parameter int unsigned HRST_MIN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_clr_i,
  input  logic soft_rst_i,
  input  logic hw_rst_i,
  input  logic scsi_rst_i,
  output logic irq_no
);
  localparam int unsigned CW = $clog2(HRST_MIN + 1);

  logic [CW-1:0] hcnt_q;
  logic hard_go, flag_q;

  assign hard_go = hw_rst_i && (hcnt_q >= CW'(HRST_MIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hcnt_q <= '0;
    else if (!hw_rst_i)                   hcnt_q <= '0;
    else if (hcnt_q < CW'(HRST_MIN - 1))  hcnt_q <= hcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 flag_q <= 1'b0;
    else if (set_i)                              flag_q <= 1'b1;
    else if (rd_clr_i || soft_rst_i || hard_go)  flag_q <= 1'b0;
  end

  assign irq_no = ~flag_q;

  assert_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !irq_no);

  assert_scsi_keeps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && scsi_rst_i && !rd_clr_i && !soft_rst_i && !hw_rst_i) |=> !irq_no);

  assert_short_hw_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && hw_rst_i && !$past(hw_rst_i) && !rd_clr_i && !soft_rst_i) |=> !irq_no);
endmodule

// File: rtl/hbus_port_decoder.sv
module hbus_port_decoder
  import hbd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned HDATA_W     = 8,
  parameter int unsigned DDATA_W     = 16,
  parameter int unsigned PAR_W       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HRST_MIN    = 2,
  parameter logic [ADDR_W-1:0] FIFO_ADDR  = 4'h2,
  parameter logic [ADDR_W-1:0] ISTAT_ADDR = 4'h5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               cs_ni,
  input  logic               dack_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic               dmawr_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [HDATA_W-1:0] ad_i,
  input  logic [DDATA_W-1:0] dma_i,
  input  logic [PAR_W-1:0]   dmap_i,
  input  logic               irq_set_i,
  input  logic               soft_rst_i,
  input  logic               hw_rst_i,
  input  logic               scsi_rst_i,
  output logic               reg_rd_o,
  output logic               reg_wr_o,
  output logic [ADDR_W-1:0]  reg_addr_o,
  output logic [HDATA_W-1:0] reg_wdata_o,
  output logic               fifo_pop_o,
  output logic               fifo_push_o,
  output logic [DDATA_W-1:0] fifo_data_o,
  output logic [PAR_W-1:0]   fifo_par_o,
  output logic [1:0]         fifo_cnt_o,
  output logic               proto_err_o,
  output logic               irq_no
);
  logic [N_STB-1:0] stb_n, act, rise;

  always_comb begin
    stb_n          = '1;
    stb_n[S_CS]    = cs_ni;
    stb_n[S_DACK]  = dack_ni;
    stb_n[S_RD]    = rd_ni;
    stb_n[S_WR]    = wr_ni;
    stb_n[S_DMAWR] = dmawr_ni;
  end

  hbd_sync #(.W(N_STB), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_ni(stb_n), .act_o(act), .rise_o(rise)
  );

  hbd_dec #(
    .ADDR_W(ADDR_W), .HDATA_W(HDATA_W), .DDATA_W(DDATA_W), .PAR_W(PAR_W),
    .FIFO_ADDR(FIFO_ADDR)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .act_i(act), .rise_i(rise),
    .addr_i(addr_i), .ad_i(ad_i), .dma_i(dma_i), .dmap_i(dmap_i),
    .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .fifo_pop_o(fifo_pop_o), .fifo_push_o(fifo_push_o),
    .fifo_data_o(fifo_data_o), .fifo_par_o(fifo_par_o), .fifo_cnt_o(fifo_cnt_o),
    .proto_err_o(proto_err_o)
  );

  logic istat_rd;
  assign istat_rd = reg_rd_o && (reg_addr_o == ISTAT_ADDR);

  hbd_irq #(.HRST_MIN(HRST_MIN)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(irq_set_i), .rd_clr_i(istat_rd),
    .soft_rst_i(soft_rst_i), .hw_rst_i(hw_rst_i), .scsi_rst_i(scsi_rst_i),
    .irq_no(irq_no)
  );

  assert_istat_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (istat_rd && !irq_set_i) |=> irq_no);
endmodule

// File: tb/sim_hbus_port_decoder.sv
module sim_hbus_port_decoder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b11;
  logic cs_ni = 1, dack_ni = 1, rd_ni = 1, wr_ni = 1, dmawr_ni = 1;
  logic [3:0] addr_i = '0;
  logic [7:0] ad_i = '0;
  logic [15:0] dma_i = '0;
  logic [1:0] dmap_i = '0;
  logic irq_set_i = 0, soft_rst_i = 0, hw_rst_i = 0, scsi_rst_i = 0;
  logic reg_rd_o, reg_wr_o, fifo_pop_o, fifo_push_o, proto_err_o, irq_no;
  logic [3:0] reg_addr_o;
  logic [7:0] reg_wdata_o;
  logic [15:0] fifo_data_o;
  logic [1:0] fifo_par_o, fifo_cnt_o;

  hbus_port_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .cs_ni(cs_ni), .dack_ni(dack_ni),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .dmawr_ni(dmawr_ni), .addr_i(addr_i), .ad_i(ad_i),
    .dma_i(dma_i), .dmap_i(dmap_i), .irq_set_i(irq_set_i), .soft_rst_i(soft_rst_i),
    .hw_rst_i(hw_rst_i), .scsi_rst_i(scsi_rst_i), .reg_rd_o(reg_rd_o),
    .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .fifo_pop_o(fifo_pop_o), .fifo_push_o(fifo_push_o), .fifo_data_o(fifo_data_o),
    .fifo_par_o(fifo_par_o), .fifo_cnt_o(fifo_cnt_o), .proto_err_o(proto_err_o),
    .irq_no(irq_no)
  );

  int checks = 0, fails = 0;
  int n_rd, n_wr, n_pop, n_push;
  logic err_seen, irq_at_rd;
  logic [3:0] c_addr;
  logic [7:0] c_wdata;
  logic [15:0] c_data;
  logic [1:0] c_par, c_cnt;

  always @(negedge clk) begin
    if (reg_rd_o) begin n_rd++; c_addr = reg_addr_o; irq_at_rd = irq_no; end
    if (reg_wr_o) begin n_wr++; c_addr = reg_addr_o; c_wdata = reg_wdata_o; end
    if (fifo_pop_o) n_pop++;
    if (fifo_push_o) begin n_push++; c_data = fifo_data_o; c_par = fifo_par_o; c_cnt = fifo_cnt_o; end
    if (proto_err_o) err_seen = 1'b1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon();
    n_rd = 0; n_wr = 0; n_pop = 0; n_push = 0; err_seen = 1'b0;
  endtask

  // select phase, optional bus change, then strobe held long
  task automatic access(input logic cs, input logic dk, input logic rd, input logic wr,
                        input logic dw, input logic [7:0] ad_ph2);
    clr_mon();
    cs_ni = ~cs; dack_ni = ~dk;
    idle(4);
    ad_i = ad_ph2;
    rd_ni = ~rd; wr_ni = ~wr; dmawr_ni = ~dw;
    idle(8);
    rd_ni = 1; wr_ni = 1; dmawr_ni = 1;
    idle(2);
    cs_ni = 1; dack_ni = 1;
    idle(6);
  endtask

  task automatic t_reset();
    idle(2);
    check(irq_no == 1 && !reg_rd_o && !reg_wr_o && !fifo_push_o && !fifo_pop_o && !proto_err_o,
          "R13 reset state", {irq_no, proto_err_o}, 2'b10);
  endtask

  task automatic t_write_sep();
    mode_i = 2'b11; addr_i = 4'h3;
    access(1, 0, 0, 1, 0, 8'hA5);
    check(n_wr == 1, "R1 single pulse per write", n_wr, 1);
    check(c_addr == 4'h3 && c_wdata == 8'hA5, "R2 mode11 addr/data", {c_addr, c_wdata}, 12'h3A5);
  endtask

  task automatic t_write_single();
    mode_i = 2'b01; addr_i = 4'h7; dma_i = 16'h553C;
    access(1, 0, 0, 1, 0, 8'hFF);
    check(n_wr == 1 && c_addr == 4'h7 && c_wdata == 8'h3C, "R2 mode01 data from dma",
          {c_addr, c_wdata}, 12'h73C);
  endtask

  task automatic t_write_mux();
    mode_i = 2'b10; addr_i = 4'hF; ad_i = 8'h04;
    access(1, 0, 0, 1, 0, 8'h99);
    check(n_wr == 1 && c_addr == 4'h4 && c_wdata == 8'h99, "R3 mode10 latched addr",
          {c_addr, c_wdata}, 12'h499);
  endtask

  task automatic t_read_cs();
    mode_i = 2'b11; addr_i = 4'h1;
    access(1, 0, 1, 0, 0, 8'h00);
    check(n_rd == 1 && n_pop == 0 && c_addr == 4'h1, "R4 cs read register", {n_rd, n_pop}, 2'b10);
    addr_i = 4'h2;
    access(1, 0, 1, 0, 0, 8'h00);
    check(n_rd == 0 && n_pop == 1, "R4 cs read fifo", {n_rd, n_pop}, 2'b01);
  endtask

  task automatic t_read_dack();
    mode_i = 2'b11; addr_i = 4'h1;
    access(0, 1, 1, 0, 0, 8'h00);
    check(n_rd == 0 && n_pop == 1, "R5 dack read pops only", {n_rd, n_pop}, 2'b01);
    access(0, 1, 0, 1, 0, 8'h00);
    check(n_rd + n_wr + n_pop + n_push == 0, "R5 dack write ignored", n_wr, 0);
  endtask

  task automatic t_push_wide();
    mode_i = 2'b11; dma_i = 16'h1234; dmap_i = 2'b10;
    access(0, 1, 0, 0, 1, 8'h00);
    check(n_push == 1 && c_data == 16'h1234 && c_par == 2'b10 && c_cnt == 2,
          "R6 wide push", {c_data, c_par, c_cnt}, {16'h1234, 2'b10, 2'd2});
    access(0, 0, 0, 0, 1, 8'h00);
    check(n_push == 0, "R6 no push without dack", n_push, 0);
  endtask

  task automatic t_push_narrow();
    mode_i = 2'b00; dma_i = 16'hBEEF; dmap_i = 2'b11;
    access(0, 1, 0, 0, 1, 8'h00);
    check(n_push == 1 && c_data == 16'h00EF && c_par == 2'b01 && c_cnt == 1,
          "R7 narrow push", {c_data, c_par, c_cnt}, {16'h00EF, 2'b01, 2'd1});
  endtask

  task automatic t_overlap();
    mode_i = 2'b01; addr_i = 4'h1; dma_i = 16'h0F0F;
    access(1, 1, 0, 0, 1, 8'h00);
    check(err_seen && n_push == 0, "R8 single-bus overlap", {err_seen, n_push[0]}, 2'b10);
    mode_i = 2'b11;
    access(1, 1, 0, 0, 1, 8'h00);
    check(!err_seen && n_push == 1, "R8 dual-bus legal overlap", {err_seen, n_push[0]}, 2'b01);
    addr_i = 4'h2;
    access(1, 1, 1, 0, 0, 8'h00);
    check(err_seen && n_pop == 0, "R8 dual-bus fifo overlap", {err_seen, n_pop[0]}, 2'b10);
  endtask

  task automatic pulse_set();
    irq_set_i = 1; idle(1); irq_set_i = 0;
  endtask

  task automatic t_irq();
    pulse_set();
    check(irq_no == 0, "R9 irq asserted", irq_no, 0);
    idle(5);
    check(irq_no == 0, "R9 irq held", irq_no, 0);
    scsi_rst_i = 1; idle(3); scsi_rst_i = 0; idle(1);
    check(irq_no == 0, "R11 scsi reset keeps irq", irq_no, 0);
    mode_i = 2'b11; addr_i = 4'h5; irq_at_rd = 1'b1;
    access(1, 0, 1, 0, 0, 8'h00);
    check(n_rd == 1 && irq_at_rd == 0, "R10 irq low during status read", irq_at_rd, 0);
    check(irq_no == 1, "R10 irq cleared after status read", irq_no, 1);
    pulse_set();
    soft_rst_i = 1; idle(1); soft_rst_i = 0;
    check(irq_no == 1, "R11 soft reset clears", irq_no, 1);
    pulse_set();
    hw_rst_i = 1; idle(1); hw_rst_i = 0; idle(2);
    check(irq_no == 0, "R12 one-cycle hard reset ignored", irq_no, 0);
    hw_rst_i = 1; idle(2); hw_rst_i = 0; idle(1);
    check(irq_no == 1, "R12 two-cycle hard reset clears", irq_no, 1);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    check(irq_no == 1 && proto_err_o == 0, "R13 outputs in reset", irq_no, 1);
    rst_ni = 1;
    t_reset();
    t_write_sep();
    t_write_single();
    t_write_mux();
    t_read_cs();
    t_read_dack();
    t_push_wide();
    t_push_narrow();
    t_overlap();
    t_irq();
    finish_run();
  end
endmodule